// File: doc/BRIEF.md
# Message and Doorbell Interrupt Unit

This block is the register unit through which a host bus master and a local processor exchange short messages and doorbell notifications. Each side has its own simple register port with an address, write data, a write strobe, a read strobe and registered read data. Each direction has two 32-bit message registers. A write to a message register marks a status bit on the side that reads it. Each direction also has a doorbell register: the sending side sets its bits and the receiving side clears them by writing ones.

Each side sees its own interrupt status word and its own interrupt mask word. The status word combines the sticky message flags, flags derived from the doorbell contents and queue-condition flags taken from input pins, because the queue logic lives outside this block. Each side gets one registered level interrupt. It is high while any defined status bit is set and not masked.

Both ports use the same word map. Word 0 and word 1 hold inbound messages 0 and 1, written by the host. Word 2 and word 3 hold outbound messages 0 and 1, written by the local side. Word 4 is the inbound doorbell, word 5 the outbound doorbell, word 6 the port's own status and word 7 the port's own mask. A read returns its data on `*RdData` one clock after the read strobe.

Top module: `mbox_irq_unit`

## Requirements
- R1: Host writes to words 0/1 are read back by the local port at the same words. Local writes to words 2/3 are read back by the host at words 2/3. A write to a message word from the side that does not own it has no effect.
- R2: A message write sets the reader's status bit n (n = message index, bits 0 and 1). The reader clears it by writing 1 to that status bit. If the set and the clear happen in the same cycle, the set wins.
- R3: A host write to word 4 ORs its data into the inbound doorbell, and a local write to word 4 clears the bits written as 1. A local write to word 5 ORs its data into the outbound doorbell, and a host write to word 5 clears bits written as 1. If a set and a clear hit the same bit in the same cycle, the set wins.
- R4: Local writes to the outbound doorbell never set bits 31 to 29.
- R5: Status bit 3 is the OR of the doorbell bits for that side; on the inbound side only bits 30 to 0 count. Inbound status bit 4 (machine check) equals inbound doorbell bit 31. Neither bit changes when the status word is written.
- R6: Outbound status bit 5 follows the post-queue-not-empty pin. Inbound status bits 5, 7 and 8 follow the post-queue, post-overflow and free-overflow pins. All other status bits read 0.
- R7: Only the defined bits of a mask word can be written: bits 0, 1, 3 and 5 for outbound, and bits 0, 1, 3, 4, 5, 7 and 8 for inbound. All other mask bits read 0. After reset the defined mask bits are 1 (0x2B outbound, 0x1BB inbound).
- R8: Each interrupt output is a register that, one clock after a defined status bit is set with its mask bit 0, goes high. One clock after no such bit remains, it goes low.
- R9: After reset all message and doorbell registers, all message status flags and both interrupts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | 3 | Host word address |
| hostWdata | input | 32 | Host write data |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe |
| hostRdData | output | 32 | Host read data, valid the clock after hostRd |
| lclAddr | input | 3 | Local word address |
| lclWdata | input | 32 | Local write data |
| lclWr | input | 1 | Local write strobe |
| lclRd | input | 1 | Local read strobe |
| lclRdData | output | 32 | Local read data, valid the clock after lclRd |
| opqNotEmpty | input | 1 | Outbound post queue not empty |
| ipqNotEmpty | input | 1 | Inbound post queue condition |
| ipqOverflow | input | 1 | Inbound post queue overflow |
| ifqOverflow | input | 1 | Inbound free queue overflow |
| hostIrq | output | 1 | Interrupt toward the host |
| lclIrq | output | 1 | Interrupt toward the local processor |

## Verification
The assertions check on every cycle that:
- reserved mask bits stay 0;
- the top three outbound doorbell bits never become 1;
- a message write leaves its status flag set on the next cycle;
- a host doorbell write leaves every written bit set;
- a fully masked side has its interrupt low one cycle later.

Only the bench scenarios can show the rest:
- the read-back paths between the two ports;
- the clear-by-one behaviour;
- same-cycle set-versus-clear ordering;
- the derived doorbell and machine-check status bits and their immunity to writes;
- the one-cycle rise and fall latency of each interrupt.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int MSGS = 2;

  localparam int A_IMSG = 0;
  localparam int A_OMSG = A_IMSG + MSGS;
  localparam int A_IDB  = A_OMSG + MSGS;
  localparam int A_ODB  = A_IDB + 1;
  localparam int A_STAT = A_ODB + 1;
  localparam int A_MASK = A_STAT + 1;
  localparam int NUM_WORDS = A_MASK + 1;

  localparam int B_DB    = 3;
  localparam int B_MCHK  = 4;
  localparam int B_PQ    = 5;
  localparam int B_POVF  = 7;
  localparam int B_FOVF  = 8;
  localparam int MIN_DW  = B_FOVF + 1;

  typedef struct packed {
    logic [MSGS-1:0] hostWrImsg;
    logic [MSGS-1:0] lclWrOmsg;
    logic hostSetIdb;
    logic lclClrIdb;
    logic lclSetOdb;
    logic hostClrOdb;
    logic hostClrStat;
    logic lclClrStat;
    logic hostWrMask;
    logic lclWrMask;
    logic hostRdEn;
    logic lclRdEn;
  } mbox_strb_t;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [ADDR_W-1:0] lclAddr,
  input  logic              lclWr,
  input  logic              lclRd,
  output mbox_strb_t        strb
);
  function automatic logic hit(input logic [ADDR_W-1:0] a, input int idx);
    return a == ADDR_W'(idx);
  endfunction

  always_comb begin
    strb = '0;
    for (int i = 0; i < MSGS; i++) begin
      strb.hostWrImsg[i] = hostWr && hit(hostAddr, A_IMSG + i);
      strb.lclWrOmsg[i]  = lclWr && hit(lclAddr, A_OMSG + i);
    end
    strb.hostSetIdb  = hostWr && hit(hostAddr, A_IDB);
    strb.hostClrOdb  = hostWr && hit(hostAddr, A_ODB);
    strb.hostClrStat = hostWr && hit(hostAddr, A_STAT);
    strb.hostWrMask  = hostWr && hit(hostAddr, A_MASK);
    strb.lclClrIdb   = lclWr && hit(lclAddr, A_IDB);
    strb.lclSetOdb   = lclWr && hit(lclAddr, A_ODB);
    strb.lclClrStat  = lclWr && hit(lclAddr, A_STAT);
    strb.lclWrMask   = lclWr && hit(lclAddr, A_MASK);
    strb.hostRdEn    = hostRd;
    strb.lclRdEn     = lclRd;
  end
endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int LCL_ODB_BITS = 29
) (
  input  logic              clk,
  input  logic              rstN,
  input  mbox_strb_t        strb,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [ADDR_W-1:0] lclAddr,
  input  logic [DATA_W-1:0] lclWdata,
  input  logic              opqNotEmpty,
  input  logic              ipqNotEmpty,
  input  logic              ipqOverflow,
  input  logic              ifqOverflow,
  output logic [DATA_W-1:0] hostRdData,
  output logic [DATA_W-1:0] lclRdData,
  output logic              hostIrq,
  output logic              lclIrq
);
  localparam logic [DATA_W-1:0] OUT_DEF = DATA_W'((1 << B_PQ) | (1 << B_DB) | ((1 << MSGS) - 1));
  localparam logic [DATA_W-1:0] IN_DEF  = DATA_W'((1 << B_FOVF) | (1 << B_POVF) | (1 << B_PQ) |
                                                 (1 << B_MCHK) | (1 << B_DB) | ((1 << MSGS) - 1));
  localparam logic [DATA_W-1:0] LCL_ODB_KEEP = DATA_W'((64'd1 << LCL_ODB_BITS) - 64'd1);

  logic [DATA_W-1:0] inMsg  [MSGS];
  logic [DATA_W-1:0] outMsg [MSGS];
  logic [MSGS-1:0]   inMsgSt, outMsgSt;
  logic [DATA_W-1:0] inDb, outDb, inMask, outMask;
  logic [DATA_W-1:0] inStat, outStat;

  for (genvar g = 0; g < MSGS; g++) begin : gMsg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        inMsg[g]    <= '0;
        outMsg[g]   <= '0;
        inMsgSt[g]  <= 1'b0;
        outMsgSt[g] <= 1'b0;
      end else begin
        if (strb.hostWrImsg[g]) inMsg[g] <= hostWdata;
        if (strb.lclWrOmsg[g])  outMsg[g] <= lclWdata;
        if (strb.hostWrImsg[g])                        inMsgSt[g] <= 1'b1;
        else if (strb.lclClrStat && lclWdata[g])       inMsgSt[g] <= 1'b0;
        if (strb.lclWrOmsg[g])                         outMsgSt[g] <= 1'b1;
        else if (strb.hostClrStat && hostWdata[g])     outMsgSt[g] <= 1'b0;
      end
    end

    // R2
    msg_status_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      strb.hostWrImsg[g] |=> inMsgSt[g]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inDb    <= '0;
      outDb   <= '0;
      inMask  <= IN_DEF;
      outMask <= OUT_DEF;
    end else begin
      inDb  <= (inDb & ~(strb.lclClrIdb ? lclWdata : '0)) |
               (strb.hostSetIdb ? hostWdata : '0);
      outDb <= (outDb & ~(strb.hostClrOdb ? hostWdata : '0)) |
               (strb.lclSetOdb ? (lclWdata & LCL_ODB_KEEP) : '0);
      if (strb.lclWrMask)  inMask  <= lclWdata & IN_DEF;
      if (strb.hostWrMask) outMask <= hostWdata & OUT_DEF;
    end
  end

  always_comb begin
    outStat = '0;
    outStat[MSGS-1:0] = outMsgSt;
    outStat[B_DB]     = |outDb;
    outStat[B_PQ]     = opqNotEmpty;
    inStat = '0;
    inStat[MSGS-1:0]  = inMsgSt;
    inStat[B_DB]      = |inDb[DATA_W-2:0];
    inStat[B_MCHK]    = inDb[DATA_W-1];
    inStat[B_PQ]      = ipqNotEmpty;
    inStat[B_POVF]    = ipqOverflow;
    inStat[B_FOVF]    = ifqOverflow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostIrq <= 1'b0;
      lclIrq  <= 1'b0;
    end else begin
      hostIrq <= |(outStat & ~outMask);
      lclIrq  <= |(inStat & ~inMask);
    end
  end

  function automatic logic [DATA_W-1:0] pick(input logic [ADDR_W-1:0] a,
                                             input logic [DATA_W-1:0] st,
                                             input logic [DATA_W-1:0] mk);
    logic [DATA_W-1:0] v;
    v = '0;
    for (int i = 0; i < MSGS; i++) begin
      if (a == ADDR_W'(A_IMSG + i)) v = inMsg[i];
      if (a == ADDR_W'(A_OMSG + i)) v = outMsg[i];
    end
    if (a == ADDR_W'(A_IDB))  v = inDb;
    if (a == ADDR_W'(A_ODB))  v = outDb;
    if (a == ADDR_W'(A_STAT)) v = st;
    if (a == ADDR_W'(A_MASK)) v = mk;
    return v;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostRdData <= '0;
      lclRdData  <= '0;
    end else begin
      if (strb.hostRdEn) hostRdData <= pick(hostAddr, outStat, outMask);
      if (strb.lclRdEn)  lclRdData  <= pick(lclAddr, inStat, inMask);
    end
  end

  // R3
  host_db_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.hostSetIdb |=> ((inDb & $past(hostWdata)) == $past(hostWdata)));

  // R4
  odb_top_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outDb & ~LCL_ODB_KEEP) == '0);

  // R7
  mask_reserved_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((inMask & ~IN_DEF) == '0) && ((outMask & ~OUT_DEF) == '0));

  // R8
  host_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outMask == OUT_DEF) |=> !hostIrq);

  // R8
  lcl_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inMask == IN_DEF) |=> !lclIrq);
endmodule

// File: rtl/mbox_irq_unit.sv
module mbox_irq_unit
  import mbox_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int LCL_ODB_BITS = 29
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic              hostWr,
  input  logic              hostRd,
  output logic [DATA_W-1:0] hostRdData,
  input  logic [ADDR_W-1:0] lclAddr,
  input  logic [DATA_W-1:0] lclWdata,
  input  logic              lclWr,
  input  logic              lclRd,
  output logic [DATA_W-1:0] lclRdData,
  input  logic              opqNotEmpty,
  input  logic              ipqNotEmpty,
  input  logic              ipqOverflow,
  input  logic              ifqOverflow,
  output logic              hostIrq,
  output logic              lclIrq
);
  mbox_strb_t strb;

  initial begin
    if (DATA_W < MIN_DW || (1 << ADDR_W) < NUM_WORDS || LCL_ODB_BITS > DATA_W)
      $error("mbox_irq_unit: parameter out of range");
  end

  mbox_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .hostAddr(hostAddr), .hostWr(hostWr), .hostRd(hostRd),
    .lclAddr(lclAddr), .lclWr(lclWr), .lclRd(lclRd), .strb(strb)
  );

  mbox_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LCL_ODB_BITS(LCL_ODB_BITS)) uData (
    .clk(clk), .rstN(rstN), .strb(strb),
    .hostAddr(hostAddr), .hostWdata(hostWdata),
    .lclAddr(lclAddr), .lclWdata(lclWdata),
    .opqNotEmpty(opqNotEmpty), .ipqNotEmpty(ipqNotEmpty),
    .ipqOverflow(ipqOverflow), .ifqOverflow(ifqOverflow),
    .hostRdData(hostRdData), .lclRdData(lclRdData),
    .hostIrq(hostIrq), .lclIrq(lclIrq)
  );
endmodule

// File: tb/mbox_irq_unit_test.sv
module mbox_irq_unit_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] hostAddr = '0, lclAddr = '0;
  logic [31:0] hostWdata = '0, lclWdata = '0;
  logic hostWr = 0, hostRd = 0, lclWr = 0, lclRd = 0;
  logic opqNotEmpty = 0, ipqNotEmpty = 0, ipqOverflow = 0, ifqOverflow = 0;
  logic [31:0] hostRdData, lclRdData;
  logic hostIrq, lclIrq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [32:0] expQ[$];
  string tagQ[$];
  logic hostRdSeen = 0, lclRdSeen = 0;

  always #2.5 clk = ~clk;

  mbox_irq_unit uut (
    .clk(clk), .rstN(rstN),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostWr(hostWr), .hostRd(hostRd),
    .hostRdData(hostRdData),
    .lclAddr(lclAddr), .lclWdata(lclWdata), .lclWr(lclWr), .lclRd(lclRd),
    .lclRdData(lclRdData),
    .opqNotEmpty(opqNotEmpty), .ipqNotEmpty(ipqNotEmpty),
    .ipqOverflow(ipqOverflow), .ifqOverflow(ifqOverflow),
    .hostIrq(hostIrq), .lclIrq(lclIrq)
  );

  always @(posedge clk) begin
    hostRdSeen <= hostRd;
    lclRdSeen  <= lclRd;
  end

  // monitor: pops one expected item per completed read
  always @(negedge clk) begin
    if ((hostRdSeen || lclRdSeen) && expQ.size() > 0) begin
      logic [32:0] e;
      string t;
      logic [31:0] act;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      act = e[32] ? lclRdData : hostRdData;
      checks++;
      if (act !== e[31:0]) begin
        errors++;
        $display("FAIL %s: actual %08h expected %08h", t, act, e[31:0]);
      end
    end
  end

  task automatic hostWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); hostAddr = a; hostWdata = d; hostWr = 1;
    @(negedge clk); hostWr = 0;
  endtask

  task automatic lclWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); lclAddr = a; lclWdata = d; lclWr = 1;
    @(negedge clk); lclWr = 0;
  endtask

  task automatic dualWrite(input logic [2:0] ha, input logic [31:0] hd,
                           input logic [2:0] la, input logic [31:0] ld);
    @(negedge clk); hostAddr = ha; hostWdata = hd; hostWr = 1;
    lclAddr = la; lclWdata = ld; lclWr = 1;
    @(negedge clk); hostWr = 0; lclWr = 0;
  endtask

  task automatic hostRead(input logic [2:0] a, input logic [31:0] e, input string t);
    @(negedge clk); hostAddr = a; hostRd = 1;
    expQ.push_back({1'b0, e}); tagQ.push_back(t);
    @(negedge clk); hostRd = 0;
  endtask

  task automatic lclRead(input logic [2:0] a, input logic [31:0] e, input string t);
    @(negedge clk); lclAddr = a; lclRd = 1;
    expQ.push_back({1'b1, e}); tagQ.push_back(t);
    @(negedge clk); lclRd = 0;
  endtask

  task automatic checkBit(input logic act, input logic e, input string t);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", t, act, e);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;

    // R9 / R7 reset state
    @(negedge clk);
    checkBit(hostIrq, 0, "R9 hostIrq reset");
    checkBit(lclIrq, 0, "R9 lclIrq reset");
    hostRead(3'd7, 32'h2B, "R7 out mask reset");
    lclRead(3'd7, 32'h1BB, "R7 in mask reset");
    lclRead(3'd0, 32'h0, "R9 in msg0 reset");
    hostRead(3'd5, 32'h0, "R9 out doorbell reset");

    // R1 message paths
    hostWrite(3'd0, 32'hA5A5_0001);
    hostWrite(3'd1, 32'h5A5A_0002);
    lclWrite(3'd2, 32'h1234_5678);
    lclWrite(3'd3, 32'h8765_4321);
    lclWrite(3'd0, 32'hDEAD_BEEF);
    lclRead(3'd0, 32'hA5A5_0001, "R1 in msg0");
    lclRead(3'd1, 32'h5A5A_0002, "R1 in msg1");
    hostRead(3'd2, 32'h1234_5678, "R1 out msg0");
    hostRead(3'd3, 32'h8765_4321, "R1 out msg1");

    // R2 status flags
    lclRead(3'd6, 32'h3, "R2 in status after msg writes");
    hostRead(3'd6, 32'h3, "R2 out status after msg writes");
    lclWrite(3'd6, 32'h1);
    lclRead(3'd6, 32'h2, "R2 in status after clear bit0");

    // R8 interrupt latency
    lclWrite(3'd7, 32'h1B9);
    checkBit(lclIrq, 0, "R8 lclIrq not yet high");
    @(negedge clk);
    checkBit(lclIrq, 1, "R8 lclIrq high");
    lclWrite(3'd6, 32'h2);
    checkBit(lclIrq, 1, "R8 lclIrq still high");
    @(negedge clk);
    checkBit(lclIrq, 0, "R8 lclIrq dropped");

    // R3 inbound doorbell
    hostWrite(3'd4, 32'h0000_00F0);
    hostWrite(3'd4, 32'h0000_0F00);
    lclRead(3'd4, 32'h0000_0FF0, "R3 in doorbell OR");
    lclWrite(3'd4, 32'h0000_00F0);
    lclRead(3'd4, 32'h0000_0F00, "R3 in doorbell clear");

    // R5 derived doorbell status bits
    lclRead(3'd6, 32'h8, "R5 in status doorbell bit");
    lclWrite(3'd6, 32'h18);
    lclRead(3'd6, 32'h8, "R5 status write no effect");
    hostWrite(3'd4, 32'h8000_0000);
    lclRead(3'd6, 32'h18, "R5 machine check bit");
    lclWrite(3'd4, 32'hFFFF_FFFF);
    lclRead(3'd6, 32'h0, "R5 doorbell cleared");

    // R3 / R2 same-cycle set versus clear
    dualWrite(3'd4, 32'h1, 3'd4, 32'h1);
    lclRead(3'd4, 32'h1, "R3 set wins over clear");
    dualWrite(3'd0, 32'h0BAD_0BAD, 3'd6, 32'h1);
    lclRead(3'd6, 32'h9, "R2 set wins over clear");

    // R4 outbound doorbell top bits
    lclWrite(3'd5, 32'hFFFF_FFFF);
    hostRead(3'd5, 32'h1FFF_FFFF, "R4 top bits ignored");
    hostWrite(3'd5, 32'h1000_0001);
    hostRead(3'd5, 32'h0FFF_FFFE, "R3 out doorbell clear");

    // R6 queue pins and reserved bits
    hostWrite(3'd6, 32'h3);
    hostRead(3'd6, 32'h08, "R6 out status before pin");
    @(negedge clk); opqNotEmpty = 1;
    hostRead(3'd6, 32'h28, "R6 out status with pin");
    @(negedge clk); ipqNotEmpty = 1; ipqOverflow = 1; ifqOverflow = 1;
    lclRead(3'd6, 32'h1A9, "R6 in status with pins");
    lclWrite(3'd6, 32'hFFFF_FFFF);
    lclRead(3'd6, 32'h1A8, "R6 in status reserved zero");

    // R7 mask write filtering, R8 host interrupt
    hostWrite(3'd7, 32'hFFFF_FFFF);
    hostRead(3'd7, 32'h2B, "R7 out mask defined only");
    lclWrite(3'd7, 32'hFFFF_FFFF);
    lclRead(3'd7, 32'h1BB, "R7 in mask defined only");
    checkBit(hostIrq, 0, "R8 hostIrq masked");
    hostWrite(3'd7, 32'h0);
    hostRead(3'd7, 32'h0, "R7 out mask cleared");
    checkBit(hostIrq, 1, "R8 hostIrq unmasked");
    @(negedge clk); opqNotEmpty = 0;
    hostWrite(3'd5, 32'hFFFF_FFFF);
    checkBit(hostIrq, 1, "R8 hostIrq before drop");
    @(negedge clk);
    checkBit(hostIrq, 0, "R8 hostIrq dropped");

    repeat (3) @(negedge clk);
    finish();
  end
endmodule